// File: doc/BRIEF.md
# Studio-Range YCbCr to RGB Pixel Converter

This block turns a stream of 8-bit studio-range YCbCr pixels into 8-bit full-range RGB, one pixel per clock. It subtracts the black-level offset from luma and the mid-scale offset from both chroma samples. It then weights each term with a fixed integer coefficient, which is the real coefficient multiplied by 2048. The weighted terms of each colour are added, rounded to the nearest integer, scaled back down by 2^11 and saturated to 0..255.

The datapath has three register stages: offset removal, weighting, then summation with clamping. A qualifier enters with every pixel and leaves with the matching RGB triple exactly three clocks later. Gaps in the input stream appear as the same gaps at the output. It sits between a video decoder and a display pixel path.

Top module: `ycc2rgb_pipe`

## Requirements
- R1: While reset is held low, and on the first clock after it, `px_vld_o` is 0 and `red_o`, `grn_o`, `blu_o` are all 0.
- R2: The red output equals floor((2384*(Y-16) + 3269*(Cr-128) + 1024) / 2048), clamped to 0..255.
- R3: The green output equals floor((2384*(Y-16) - 1665*(Cr-128) - 803*(Cb-128) + 1024) / 2048), clamped to 0..255.
- R4: The blue output equals floor((2384*(Y-16) + 4131*(Cb-128) + 1024) / 2048), clamped to 0..255.
- R5: A colour whose rounded, scaled result is below zero is output as 0.
- R6: A colour whose rounded, scaled result exceeds 255 is output as 255.
- R7: `px_vld_o` is high exactly three clocks after a clock edge at which `px_vld_i` was sampled high, and the RGB sampled then belongs to that pixel.
- R8: A new pixel is accepted on every clock. Back-to-back pixels come out back-to-back, in order and without loss.
- R9: An input with Cb = Cr = 128 produces R = G = B three clocks later.
- R10: Input codes outside the nominal ranges (Y below 16 or above 235, chroma below 16 or above 240) pass through the same formulas without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| px_vld_i | input | 1 | Input pixel qualifier |
| luma_i | input | 8 | Y sample |
| cb_i | input | 8 | Blue-difference chroma sample |
| cr_i | input | 8 | Red-difference chroma sample |
| px_vld_o | output | 1 | Output pixel qualifier |
| red_o | output | 8 | Red component |
| grn_o | output | 8 | Green component |
| blu_o | output | 8 | Blue component |

## Verification
The assertions watch the behaviour that holds on every cycle. Each saturation branch must give 0 or 255 on the clock after its sum goes out of range. Every output qualifier must trace back to an input qualifier three clocks earlier. Neutral chroma must give equal components. The exact arithmetic can only be shown by the bench's scenarios, which compare every output against a behavioural model: the rounding at half-step boundaries, the green cross terms, codes outside the nominal range, and streams with gaps.

// File: rtl/ycc_pkg.sv
// Shared constants of the YCbCr to RGB converter.
// Assumes 8-bit studio-range input; coefficients are real values times 2^FRAC.
package ycc_pkg;
    localparam int FRAC       = 11;
    localparam int K_LUMA     = 2384;
    localparam int K_RED_CR   = 3269;
    localparam int K_GRN_CR   = 1665;
    localparam int K_GRN_CB   = 803;
    localparam int K_BLU_CB   = 4131;
    localparam int LUMA_BASE  = 16;
    localparam int CHROMA_MID = 128;
endpackage

// File: rtl/ycc_unbias.sv
// Stage 1: removes the luma black level and the chroma mid-scale offset.
// Assumes unsigned DW-bit codes; outputs are signed and two bits wider.
module ycc_unbias
    import ycc_pkg::*;
#(
    parameter int DW = 8,
    localparam int SW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic [DW-1:0]        y_i,
    input  logic [DW-1:0]        cb_i,
    input  logic [DW-1:0]        cr_i,
    output logic                 vld_o,
    output logic signed [SW-1:0] y_o,
    output logic signed [SW-1:0] cb_o,
    output logic signed [SW-1:0] cr_o
);
    localparam logic signed [SW-1:0] Y_BASE = SW'(LUMA_BASE);
    localparam logic signed [SW-1:0] C_MID  = SW'(CHROMA_MID);

    // Register the offset-free samples and their qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            y_o   <= '0;
            cb_o  <= '0;
            cr_o  <= '0;
        end else begin
            vld_o <= vld_i;
            y_o   <= $signed({2'b00, y_i})  - Y_BASE;
            cb_o  <= $signed({2'b00, cb_i}) - C_MID;
            cr_o  <= $signed({2'b00, cr_i}) - C_MID;
        end
    end
endmodule

// File: rtl/ycc_weigh.sv
// Stage 2: multiplies the offset-free samples by the scaled coefficients.
// Assumes AW is wide enough for the largest weighted sum; produces one shared
// luma term and one chroma term per output colour.
module ycc_weigh
    import ycc_pkg::*;
#(
    parameter int SW = 10,
    parameter int AW = 25
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic signed [SW-1:0] y_i,
    input  logic signed [SW-1:0] cb_i,
    input  logic signed [SW-1:0] cr_i,
    output logic                 vld_o,
    output logic signed [AW-1:0] luma_t,
    output logic signed [AW-1:0] red_t,
    output logic signed [AW-1:0] grn_t,
    output logic signed [AW-1:0] blu_t
);
    localparam logic signed [AW-1:0] KY  = AW'(K_LUMA);
    localparam logic signed [AW-1:0] KRV = AW'(K_RED_CR);
    localparam logic signed [AW-1:0] KGV = AW'(K_GRN_CR);
    localparam logic signed [AW-1:0] KGU = AW'(K_GRN_CB);
    localparam logic signed [AW-1:0] KBU = AW'(K_BLU_CB);

    logic signed [AW-1:0] y_x, cb_x, cr_x;

    // Sign-extend the samples to accumulator width.
    always_comb begin
        y_x  = AW'(y_i);
        cb_x = AW'(cb_i);
        cr_x = AW'(cr_i);
    end

    // Register the weighted terms and their qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            luma_t <= '0;
            red_t  <= '0;
            grn_t  <= '0;
            blu_t  <= '0;
        end else begin
            vld_o  <= vld_i;
            luma_t <= KY * y_x;
            red_t  <= KRV * cr_x;
            grn_t  <= -((KGV * cr_x) + (KGU * cb_x));
            blu_t  <= KBU * cb_x;
        end
    end
endmodule

// File: rtl/ycc_clip.sv
// Stage 3 for one colour: adds the luma and chroma terms, rounds, scales down
// by 2^FRAC and saturates to the unsigned DW-bit range.
// Assumes two's-complement terms that cannot overflow AW bits when summed.
module ycc_clip
    import ycc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 25
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [AW-1:0] luma_t,
    input  logic signed [AW-1:0] chroma_t,
    output logic [DW-1:0]        q
);
    localparam logic signed [AW-1:0] HALF = AW'(1 << (FRAC - 1));
    localparam logic signed [AW-1:0] TOP  = AW'((1 << DW) - 1);

    logic signed [AW-1:0] total, scaled;

    // Round to nearest and scale back down.
    always_comb begin
        total  = luma_t + chroma_t + HALF;
        scaled = total >>> FRAC;
    end

    // Register the saturated component.
    always_ff @(posedge clk) begin
        if (!rst_n)               q <= '0;
        else if (scaled < 0)      q <= '0;
        else if (scaled > TOP)    q <= '1;
        else                      q <= scaled[DW-1:0];
    end

    AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (scaled < 0) |=> (q == '0));  // R5
    AST_CEIL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (scaled > TOP) |=> (q == '1));  // R6
endmodule

// File: rtl/ycc2rgb_pipe.sv
// Top: three-stage YCbCr to RGB converter, one pixel per clock.
// Assumes studio-range 8-bit input; latency is fixed at three clocks and the
// qualifier is delayed alongside the data.
module ycc2rgb_pipe
    import ycc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          px_vld_i,
    input  logic [DW-1:0] luma_i,
    input  logic [DW-1:0] cb_i,
    input  logic [DW-1:0] cr_i,
    output logic          px_vld_o,
    output logic [DW-1:0] red_o,
    output logic [DW-1:0] grn_o,
    output logic [DW-1:0] blu_o
);
    localparam int SW = DW + 2;
    localparam int AW = DW + FRAC + 6;
    localparam int NCH = 3;

    logic                 vld1, vld2;
    logic signed [SW-1:0] y1, cb1, cr1;
    logic signed [AW-1:0] luma2;
    logic signed [AW-1:0] chroma2 [NCH];
    logic [DW-1:0]        px3 [NCH];

    ycc_unbias #(.DW(DW)) u_unbias (
        .clk(clk), .rst_n(rst_n), .vld_i(px_vld_i),
        .y_i(luma_i), .cb_i(cb_i), .cr_i(cr_i),
        .vld_o(vld1), .y_o(y1), .cb_o(cb1), .cr_o(cr1)
    );

    ycc_weigh #(.SW(SW), .AW(AW)) u_weigh (
        .clk(clk), .rst_n(rst_n), .vld_i(vld1),
        .y_i(y1), .cb_i(cb1), .cr_i(cr1),
        .vld_o(vld2), .luma_t(luma2),
        .red_t(chroma2[0]), .grn_t(chroma2[1]), .blu_t(chroma2[2])
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        ycc_clip #(.DW(DW), .AW(AW)) u_clip (
            .clk(clk), .rst_n(rst_n),
            .luma_t(luma2), .chroma_t(chroma2[ch]), .q(px3[ch])
        );
    end

    // Delay the qualifier through the final stage.
    always_ff @(posedge clk) begin
        if (!rst_n) px_vld_o <= 1'b0;
        else        px_vld_o <= vld2;
    end

    // Map per-channel results onto the output ports.
    always_comb begin
        red_o = px3[0];
        grn_o = px3[1];
        blu_o = px3[2];
    end

    AST_VALID_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
        px_vld_o |-> $past(px_vld_i, 3));  // R7
    AST_NEUTRAL_GRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (px_vld_i && cb_i == DW'(CHROMA_MID) && cr_i == DW'(CHROMA_MID))
        |-> ##3 (red_o == grn_o && grn_o == blu_o));  // R9
endmodule

// File: tb/sim_ycc2rgb_pipe.sv
module sim_ycc2rgb_pipe;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld = 1'b0;
    logic [7:0] y = '0, cb = '0, cr = '0;
    logic       o_vld;
    logic [7:0] o_r, o_g, o_b;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;
    string req = "R1";

    // Behavioural model: three-entry delay of qualifier and expected colours.
    bit m_vld [3];
    int m_r [3], m_g [3], m_b [3];

    always #4 clk = ~clk;

    ycc2rgb_pipe u0 (
        .clk(clk), .rst_n(rst_n), .px_vld_i(vld),
        .luma_i(y), .cb_i(cb), .cr_i(cr),
        .px_vld_o(o_vld), .red_o(o_r), .grn_o(o_g), .blu_o(o_b)
    );

    function automatic int sat(input int v);
        int s = (v + 1024) >>> 11;
        if (s < 0) return 0;
        if (s > 255) return 255;
        return s;
    endfunction

    always @(posedge clk) begin
        int yy, uu, vv;
        yy = int'(y) - 16;
        uu = int'(cb) - 128;
        vv = int'(cr) - 128;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_vld[i] = 0; m_r[i] = 0; m_g[i] = 0; m_b[i] = 0;
            end
        end else begin
            for (int i = 2; i > 0; i--) begin
                m_vld[i] = m_vld[i-1]; m_r[i] = m_r[i-1];
                m_g[i] = m_g[i-1]; m_b[i] = m_b[i-1];
            end
            m_vld[0] = vld;
            m_r[0] = sat(2384*yy + 3269*vv);
            m_g[0] = sat(2384*yy - 1665*vv - 803*uu);
            m_b[0] = sat(2384*yy + 4131*uu);
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done && rst_n) begin
            compared++;
            if (o_vld !== m_vld[2]) begin
                mismatched++;
                $display("FAIL %s R7 valid: got %0b expected %0b", req, o_vld, m_vld[2]);
            end else if (m_vld[2]) begin
                if (int'(o_r) != m_r[2] || int'(o_g) != m_g[2] || int'(o_b) != m_b[2]) begin
                    mismatched++;
                    $display("FAIL %s R2/R3/R4: got %0d,%0d,%0d expected %0d,%0d,%0d",
                             req, o_r, o_g, o_b, m_r[2], m_g[2], m_b[2]);
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    task automatic send(input int yv, input int cbv, input int crv);
        @(negedge clk);
        vld = 1'b1; y = 8'(yv); cb = 8'(cbv); cr = 8'(crv);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vld = 1'b0; y = 8'($urandom); cb = 8'($urandom); cr = 8'($urandom);
        end
    endtask

    initial begin
        // R1: reset state, checked during reset and just after release.
        repeat (3) @(negedge clk);
        compared++;
        if (o_vld !== 1'b0 || o_r !== 8'd0 || o_g !== 8'd0 || o_b !== 8'd0) begin
            mismatched++;
            $display("FAIL R1 in reset: got %0b %0d,%0d,%0d expected 0 0,0,0", o_vld, o_r, o_g, o_b);
        end
        rst_n = 1'b1;
        @(negedge clk);
        compared++;
        if (o_vld !== 1'b0 || o_r !== 8'd0 || o_g !== 8'd0 || o_b !== 8'd0) begin
            mismatched++;
            $display("FAIL R1 after release: got %0b %0d,%0d,%0d expected 0 0,0,0", o_vld, o_r, o_g, o_b);
        end

        // R9: neutral chroma across the luma range, including black and white.
        req = "R9";
        send(16, 128, 128); send(235, 128, 128); send(126, 128, 128);
        idle(4);

        // R2, R3, R4: colour primaries and a fixed reference pixel.
        req = "R2";
        send(81, 90, 240);
        req = "R3";
        send(145, 54, 34);
        req = "R4";
        send(41, 240, 110);
        idle(4);

        // R5: negative results clamp to zero.
        req = "R5";
        send(0, 128, 128); send(16, 16, 16); send(20, 255, 0);
        idle(4);

        // R6: results above full scale clamp to 255.
        req = "R6";
        send(255, 128, 128); send(235, 240, 240); send(200, 0, 255);
        idle(4);

        // R10: codes outside the nominal ranges.
        req = "R10";
        for (int v = 0; v < 256; v += 5) send(v, 255 - v, v);
        idle(3);

        // R8: long back-to-back random stream.
        req = "R8";
        for (int i = 0; i < 2000; i++) send($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));

        // R7: random stream with gaps.
        req = "R7";
        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
            send($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
        end
        idle(6);

        done = 1'b1;
        report();
    end
endmodule